// File: doc/BRIEF.md
# Readback-Capable Address Latch for a Dual 4:1 Switch Matrix

This block is the digital control for a switch matrix with two sections, each of which routes one of four inputs to its output. A small group of shared bidirectional pins carries a two-bit channel address and an enable bit. When the write strobe is low and the direction control is low, the block captures the pin values into its latch. When the strobe and the direction control are both high, the block drives the stored value back onto the same pins, so a host can read back the last address it wrote.

The stored value is decoded into one-hot switch-close signals. Both sections share the address. An active-low direct reset clears the stored value and opens every switch at once, whatever the other controls are doing. Each bidirectional pin is split into an input, an output and an output-enable signal.

Top module: `addr_readback_latch`

## Requirements
- R1: With rs_n=1, wr_n=0 and io_dir=0, the value on pin_in is stored at the rising clock edge. Bits 1:0 of the pins are the address A1:A0, and bit 2 is the enable.
- R2: With rs_n=1, wr_n=1 and io_dir=1, pin_oe is all ones and pin_out carries the stored enable and address in the R1 bit layout. In every other combination, pin_oe is all zeros.
- R3: With rs_n=1, wr_n=1 and io_dir=0, pin_oe is zero and the stored value is held, whatever pin_in carries.
- R4: With rs_n=1, wr_n=0 and io_dir=1, nothing happens. The stored value is held and pin_oe is zero.
- R5: While rs_n=0, all switch-close outputs and pin_oe are zero at once, and the stored value becomes zero at the next rising edge.
- R6: When the stored enable is 1, exactly one switch per section is closed. In section s, that is sw_close bit s*4+A, where A is the stored A1:A0, so address 00 closes channel 1 (bit 0 of the section).
- R7: When the stored enable is 0, every switch-close output is 0.
- R8: After reset is released, a readback returns 0 and no switch is closed until the first write.
- R9: A readback returns the last value written, even after hold and no-operation cycles that present other values on pin_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rs_n | input | 1 | Active-low direct reset (synchronous clear, immediate switch open) |
| wr_n | input | 1 | Active-low write strobe |
| io_dir | input | 1 | Direction control: 0 = entry/hold, 1 = readback |
| pin_in | input | 3 | Values seen on the address/enable pins {en, A1, A0} |
| pin_out | output | 3 | Value driven onto the pins during readback |
| pin_oe | output | 3 | Per-pin output enable, high only in readback |
| sw_close | output | 8 | Switch-close outputs, section s channel c at bit s*4+c |

## Verification
All eight pin codes are written in turn. Each is then read back and compared against the decoded switch pattern, which separates enable-off codes from each address under enable-on and catches wrong bit ordering between the sections. After each write, hold and no-operation cycles present the complemented code on the pins, and a readback shows that the stored value did not move. Reset is applied while a switch is closed, and also during the write and readback states, to show that it takes priority over both.

// File: rtl/addr_ctl_pkg.sv
// Package: shared widths and the stored-word layout for the address latch.
// Assumes a two-bit address and two sections unless overridden at the top.
package addr_ctl_pkg;
    localparam int unsigned ADDR_BITS    = 2;
    localparam int unsigned SECTION_CNT  = 2;
    localparam int unsigned CHAN_PER_SEC = 1 << ADDR_BITS;

    // Operating state selected by the control pins.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2,
        MODE_NOOP  = 2'd3
    } ctl_mode_t;
endpackage

// File: rtl/addr_mode_decode.sv
// Module: addr_mode_decode
// Turns the strobe, direction and reset pins into a mode, a write enable
// and a pin-drive enable. Assumes the controls are already synchronous to clk.
module addr_mode_decode
    import addr_ctl_pkg::*;
(
    input  logic      rs_n,
    input  logic      wr_n,
    input  logic      io_dir,
    output ctl_mode_t mode,
    output logic      write_en,
    output logic      drive_en
);
    // Pick the mode from the strobe and the direction control.
    always_comb begin
        unique case ({io_dir, wr_n})
            2'b00:   mode = MODE_WRITE;
            2'b01:   mode = MODE_HOLD;
            2'b11:   mode = MODE_READ;
            default: mode = MODE_NOOP;
        endcase
    end

    // Reset blocks both capture and drive.
    always_comb begin
        write_en = rs_n && (mode == MODE_WRITE);
        drive_en = rs_n && (mode == MODE_READ);
    end
endmodule

// File: rtl/addr_latch_reg.sv
// Module: addr_latch_reg
// Stores the enable and address word. It loads on write_en and clears on
// a synchronous active-low reset. Assumes write_en is already gated by reset.
module addr_latch_reg #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rs_n,
    input  logic             write_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the pins when writing, clear on reset, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rs_n)
            q <= '0;
        else if (write_en)
            q <= d;
    end

    a_r1_write_capture: assert property (@(posedge clk) disable iff (!rs_n)
        write_en |=> (q == $past(d)));
    a_r3_hold_value: assert property (@(posedge clk) disable iff (!rs_n)
        !write_en |=> $stable(q));
    a_r5_reset_clear: assert property (@(posedge clk)
        !rs_n |=> (q == '0));
endmodule

// File: rtl/switch_decode.sv
// Module: switch_decode
// Decodes the stored address into one-hot switch closes, one group per section.
// Assumes every section shares the same address. Outputs stay low while
// active is low.
module switch_decode #(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned SECTIONS = 2
) (
    input  logic                             clk,
    input  logic                             rs_n,
    input  logic                             active,
    input  logic [ADDR_W-1:0]                addr,
    output logic [SECTIONS*(1<<ADDR_W)-1:0]  sw_close
);
    localparam int unsigned CHANS = 1 << ADDR_W;

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        logic [CHANS-1:0] sec_sel;

        // One-hot select for this section, or all open.
        always_comb begin
            sec_sel = '0;
            if (active)
                sec_sel[addr] = 1'b1;
        end

        assign sw_close[s*CHANS +: CHANS] = sec_sel;

        a_r6_one_per_section: assert property (@(posedge clk) disable iff (!rs_n)
            active |-> ($countones(sw_close[s*CHANS +: CHANS]) == 1));
        a_r7_all_open: assert property (@(posedge clk)
            !active |-> (sw_close[s*CHANS +: CHANS] == '0));
    end
endmodule

// File: rtl/addr_readback_latch.sv
// Module: addr_readback_latch (top)
// Address and enable latch with readback on shared pins and a switch-close decode.
// Pin layout: the low ADDR_W bits are the address and the top bit is the enable.
// Assumes all controls are synchronous to clk.
module addr_readback_latch
    import addr_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_BITS,
    parameter int unsigned SECTIONS = SECTION_CNT
) (
    input  logic                            clk,
    input  logic                            rs_n,
    input  logic                            wr_n,
    input  logic                            io_dir,
    input  logic [ADDR_W:0]                 pin_in,
    output logic [ADDR_W:0]                 pin_out,
    output logic [ADDR_W:0]                 pin_oe,
    output logic [SECTIONS*(1<<ADDR_W)-1:0] sw_close
);
    localparam int unsigned PIN_W = ADDR_W + 1;

    ctl_mode_t        mode;
    logic             write_en;
    logic             drive_en;
    logic [PIN_W-1:0] stored;
    logic             sw_active;

    addr_mode_decode i_mode (
        .rs_n     (rs_n),
        .wr_n     (wr_n),
        .io_dir   (io_dir),
        .mode     (mode),
        .write_en (write_en),
        .drive_en (drive_en)
    );

    addr_latch_reg #(.WIDTH(PIN_W)) i_latch (
        .clk      (clk),
        .rs_n     (rs_n),
        .write_en (write_en),
        .d        (pin_in),
        .q        (stored)
    );

    // Switches close only while out of reset and with the stored enable set.
    always_comb sw_active = rs_n && stored[ADDR_W];

    switch_decode #(.ADDR_W(ADDR_W), .SECTIONS(SECTIONS)) i_sw (
        .clk      (clk),
        .rs_n     (rs_n),
        .active   (sw_active),
        .addr     (stored[ADDR_W-1:0]),
        .sw_close (sw_close)
    );

    // Readback drive: the stored word, enabled on every pin together.
    always_comb begin
        pin_out = stored;
        pin_oe  = {PIN_W{drive_en}};
    end

    a_r2_drive_only_readback: assert property (@(posedge clk)
        (pin_oe != '0) |-> (rs_n && wr_n && io_dir && (mode == MODE_READ)));
    a_r4_noop_no_drive: assert property (@(posedge clk) disable iff (!rs_n)
        (io_dir && !wr_n) |-> (pin_oe == '0));
    a_r4_noop_hold: assert property (@(posedge clk) disable iff (!rs_n)
        (io_dir && !wr_n) |=> $stable(pin_out));
    a_r5_reset_opens: assert property (@(posedge clk)
        !rs_n |-> ((sw_close == '0) && (pin_oe == '0)));
endmodule

// File: tb/test_addr_readback_latch.sv
module test_addr_readback_latch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rs_n, wr_n, io_dir;
    logic [2:0] pin_in;
    logic [2:0] pin_out, pin_oe;
    logic [7:0] sw_close;
    int checks = 0;
    int errors = 0;

    addr_readback_latch i_addr_readback_latch (
        .clk(clk), .rs_n(rs_n), .wr_n(wr_n), .io_dir(io_dir),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .sw_close(sw_close)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_sw(input logic [2:0] v);
        logic [7:0] r = '0;
        if (v[2]) begin
            r[v[1:0]]     = 1'b1;
            r[4 + v[1:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply controls at the falling edge, then wait one rising edge.
    task automatic cyc(input logic r, input logic w, input logic d, input logic [2:0] p);
        @(negedge clk);
        rs_n = r; wr_n = w; io_dir = d; pin_in = p;
        @(posedge clk);
        #1;
    endtask

    // Enter readback and check the pins and switches before any edge.
    task automatic readback(input string req, input logic [2:0] exp);
        @(negedge clk);
        rs_n = 1; wr_n = 1; io_dir = 1; pin_in = 3'b000;
        #1;
        chk(req, {13'd0, pin_oe}, 16'h0007);
        chk(req, {13'd0, pin_out}, {13'd0, exp});
        chk(req, {8'd0, sw_close}, {8'd0, exp_sw(exp)});
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rs_n = 0; wr_n = 1; io_dir = 0; pin_in = 3'b111;
        cyc(0, 1, 0, 3'b111);
        cyc(0, 1, 0, 3'b111);
        chk("R5 reset oe", {13'd0, pin_oe}, 0);
        chk("R5 reset sw", {8'd0, sw_close}, 0);
        cyc(1, 1, 0, 3'b111);
        chk("R8 no switch after reset", {8'd0, sw_close}, 0);
        readback("R8 readback after reset", 3'b000);

        for (int v = 0; v < 8; v++) begin
            cyc(1, 0, 0, v[2:0]);  // R1 write
            chk("R1 hold oe off", {13'd0, pin_oe}, 0);
            chk(v[2] ? "R6 decode" : "R7 all open", {8'd0, sw_close}, {8'd0, exp_sw(v[2:0])});
            readback("R2 readback", v[2:0]);
            cyc(1, 1, 0, ~v[2:0]);  // R3 hold, complemented pins
            chk("R3 hold no drive", {13'd0, pin_oe}, 0);
            cyc(1, 0, 1, ~v[2:0]);  // R4 no-op
            chk("R4 noop no drive", {13'd0, pin_oe}, 0);
            cyc(1, 0, 1, ~v[2:0]);
            readback("R9 last written kept", v[2:0]);
        end

        // Reset while a switch is closed and during a write.
        cyc(1, 0, 0, 3'b110);
        chk("R6 closed before reset", {8'd0, sw_close}, 8'h44);
        @(negedge clk);
        rs_n = 0; wr_n = 0; io_dir = 0; pin_in = 3'b101;
        #1;
        chk("R5 immediate open", {8'd0, sw_close}, 0);
        @(posedge clk);
        #1;
        // Reset held in the readback state: nothing is driven.
        cyc(0, 1, 1, 3'b000);
        chk("R5 no drive in reset", {13'd0, pin_oe}, 0);
        cyc(1, 1, 0, 3'b000);
        readback("R5 cleared by reset", 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule